// File: doc/BRIEF.md
# Address Correlation Prefetcher

This block watches a stream of demand accesses, each given as a cache-block address rather than a byte address, and learns which block tends to follow which. It keeps a small fully associative table. Each entry pairs a trigger block with the single block seen right after it most recently. On every access, the block looks the incoming address up in the table. If an entry matches, the block issues that entry's successor as a prefetch request one cycle later. It then records the incoming address as the successor of the access before it. Only the latest observed successor is kept, and no confidence counting is done.

The table is empty after reset. When a new trigger has to be stored and every slot is taken, the entry touched least recently is replaced. Each entry carries an age counter that tracks recency. Both kinds of touch make an entry the most recent: having its successor written, and matching a lookup.

Top module: `markov_prefetch`

## Requirements
- R1: After reset, `pf_valid` is 0 and the table holds no entries, so no lookup hits until a correlation has been learned.
- R2: When `acc_valid` is high and `acc_addr` matches a stored trigger, `pf_valid` is 1 in the next cycle and `pf_addr` equals that trigger's stored successor.
- R3: In a cycle after which `acc_valid` was low, `pf_valid` is 0. No prefetch appears without an access.
- R4: The first access after reset only performs a lookup. It creates no table entry, because no previous access is known.
- R5: Each access writes its address as the successor of the previous access's trigger, replacing any older successor. A trigger holds exactly one successor.
- R6: When the previous address has no entry, a new entry is created. If all `ENTRIES` slots are in use, the least recently touched entry is evicted and its trigger no longer hits.
- R7: A lookup hit counts as a touch for recency, applied after the correlation write of the same access. If the correlation write evicts the entry that hit, that entry is gone.
- R8: The lookup sees the table as it was before the current access's update. An address whose entry is created by this same access misses.
- R9: No confidence threshold exists. A correlation observed once produces a prefetch at the next matching access, and at most one prefetch is issued per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access strobe |
| acc_addr | input | AW | Block address of the demand access |
| pf_valid | output | 1 | Prefetch request strobe, one cycle after a hitting access |
| pf_addr | output | AW | Block address to prefetch |

## Verification
The assertions check on every cycle that a prefetch only follows an access and that a lookup miss produces none. They also check that the first access after reset adds no entry, that the number of occupied entries never shrinks, and that a full table always has exactly one eviction candidate. Which successor is returned, and which entry is evicted under a given order of hits and writes, can only be seen through the bench's scenarios. The bench compares against a recency-list model, using an exhaustive sweep of all short sequences over a five-address alphabet on a four-entry table, plus directed and random streams.

// File: rtl/markov_prefetch.sv
module markov_prefetch #(
  parameter int ENTRIES = 12,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] MAXAGE = IW'(ENTRIES - 1);

  typedef logic [ENTRIES-1:0][IW-1:0] age_t;

  logic [ENTRIES-1:0] vld;
  logic [AW-1:0]      trig [ENTRIES];
  logic [AW-1:0]      succ [ENTRIES];
  age_t               age, age_a, age_b;
  logic               last_valid;
  logic [AW-1:0]      last_addr;

  logic [ENTRIES-1:0] hit_vec, own_vec, vic_vec;
  logic [IW-1:0]      hit_idx, own_idx, vic_idx, wr_idx;
  logic               hit, own, wr_en, ins, keep_hit;

  function automatic age_t touch(input age_t a, input logic [IW-1:0] k);
    age_t r;
    logic [IW-1:0] old;
    old = a[k];
    for (int i = 0; i < ENTRIES; i++) begin
      if (IW'(i) == k)     r[i] = '0;
      else if (a[i] < old) r[i] = a[i] + IW'(1);
      else                 r[i] = a[i];
    end
    return r;
  endfunction

  always_comb begin
    hit_idx = '0;
    own_idx = '0;
    vic_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = vld[i] && (trig[i] == acc_addr);
      own_vec[i] = vld[i] && (trig[i] == last_addr);
      vic_vec[i] = (age[i] == MAXAGE);
      if (hit_vec[i]) hit_idx = IW'(i);
      if (own_vec[i]) own_idx = IW'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (vic_vec[i]) vic_idx = IW'(i);
  end

  assign hit      = |hit_vec;
  assign own      = |own_vec;
  assign wr_en    = acc_valid && last_valid;
  assign ins      = wr_en && !own;
  assign wr_idx   = own ? own_idx : vic_idx;
  assign keep_hit = acc_valid && hit && !(ins && (vic_idx == hit_idx));

  always_comb begin
    age_a = wr_en ? touch(age, wr_idx) : age;
    age_b = keep_hit ? touch(age_a, hit_idx) : age_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      age        <= {ENTRIES{MAXAGE}};
      last_valid <= 1'b0;
      last_addr  <= '0;
      pf_valid   <= 1'b0;
      pf_addr    <= '0;
    end else begin
      pf_valid <= acc_valid && hit;
      if (acc_valid) begin
        last_valid <= 1'b1;
        last_addr  <= acc_addr;
        age        <= age_b;
        if (hit) pf_addr <= succ[hit_idx];
        if (wr_en) vld[wr_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      trig[wr_idx] <= last_addr;
      succ[wr_idx] <= acc_addr;
    end
  end

  p_after_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(acc_valid));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !pf_valid);

  p_first_no_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !last_valid) |=> ($countones(vld) == $past($countones(vld))));

  p_occupancy_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld) >= $past($countones(vld))));

  p_one_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld) |-> ($countones(vic_vec) == 1));

  p_miss_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit) |=> !pf_valid);
endmodule

// File: tb/markov_prefetch_tb.sv
`timescale 1ns/1ps
module markov_prefetch_tb;
  localparam int E  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          pf_valid;
  logic [AW-1:0] pf_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  markov_prefetch #(.ENTRIES(E), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr));

  always #2 clk = ~clk;

  // recency-ordered model, position 0 is the most recently touched entry
  logic [AW-1:0] m_t [E];
  logic [AW-1:0] m_s [E];
  int            m_n;
  bit            m_lv;
  logic [AW-1:0] m_last;
  bit            exp_v;
  logic [AW-1:0] exp_a;
  string         exp_tag;

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < m_n; i++) if (m_t[i] == a) return i;
    return -1;
  endfunction

  task automatic front(input int p);
    logic [AW-1:0] t, s;
    t = m_t[p]; s = m_s[p];
    for (int i = p; i > 0; i--) begin m_t[i] = m_t[i-1]; m_s[i] = m_s[i-1]; end
    m_t[0] = t; m_s[0] = s;
  endtask

  task automatic insert(input logic [AW-1:0] t, input logic [AW-1:0] s);
    if (m_n < E) m_n++;
    for (int i = m_n - 1; i > 0; i--) begin m_t[i] = m_t[i-1]; m_s[i] = m_s[i-1]; end
    m_t[0] = t; m_s[0] = s;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [AW-1:0] a, input string tag);
    int hp, p;
    @(negedge clk);
    chk(pf_valid == exp_v, exp_tag, "pf_valid", int'(pf_valid), int'(exp_v));
    if (exp_v) chk(pf_addr == exp_a, exp_tag, "pf_addr", int'(pf_addr), int'(exp_a));
    acc_valid = v;
    acc_addr  = a;
    exp_tag   = tag;
    hp = find(a);
    exp_v = v && (hp >= 0);
    exp_a = (hp >= 0) ? m_s[hp] : '0;
    if (v) begin
      if (m_lv) begin
        p = find(m_last);
        if (p >= 0) begin m_s[p] = a; front(p); end
        else insert(m_last, a);
      end
      if (hp >= 0) begin
        p = find(a);
        if (p >= 0) front(p);
      end
      m_last = a;
      m_lv   = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    acc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_n = 0; m_lv = 0; m_last = '0;
    exp_v = 0; exp_a = '0; exp_tag = "R1";
  endtask

  initial begin
    m_n = 0; m_lv = 0; m_last = '0; exp_v = 0; exp_a = '0; exp_tag = "R1";
    do_reset();
    step(0, 8'h00, "R1");

    // R4: the first access must not learn a pair from a stale previous address
    do_reset();
    step(1, 8'h00, "R4");
    step(1, 8'h00, "R4");
    step(1, 8'h00, "R4");

    // R8: lookup sees the table before this access's write
    do_reset();
    step(1, 8'h20, "R8");
    step(1, 8'h21, "R8");
    step(1, 8'h21, "R8");
    step(1, 8'h21, "R9");
    step(0, 8'h00, "R3");

    // R2 and R5: repeated pattern whose first address alternates successors
    do_reset();
    for (int r = 0; r < 8; r++) begin
      step(1, 8'h10, "R5");
      step(1, 8'h13, "R2");
      step(0, 8'h00, "R3");
      step(1, 8'h16, "R2");
      step(1, 8'h10, "R5");
      step(1, 8'h15, "R2");
    end

    // R7 and R6: a hit keeps an entry young, the untouched one is evicted
    do_reset();
    step(1, 8'h01, "R7");
    step(1, 8'h02, "R7");
    step(1, 8'h03, "R7");
    step(1, 8'h04, "R7");
    step(1, 8'h02, "R7");
    step(1, 8'h06, "R7");
    step(1, 8'h07, "R6");
    step(1, 8'h03, "R7");
    step(1, 8'h01, "R6");
    step(0, 8'h00, "R3");

    // R6: more distinct addresses than entries in a cycle
    do_reset();
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 6; k++) step(1, AW'(8'h40 + k), "R6");

    // exhaustive sweep: all length-5 sequences over five addresses
    for (int s = 0; s < 3125; s++) begin
      int x;
      do_reset();
      x = s;
      for (int k = 0; k < 5; k++) begin
        step(1, AW'(8'h80 + (x % 5)), "R5");
        x = x / 5;
      end
      step(1, AW'(8'h80 + (s % 5)), "R2");
      step(0, 8'h00, "R3");
    end

    // random stream with idle gaps
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, AW'($urandom % 7), v ? "R9" : "R3");
    end
    step(0, 8'h00, "R3");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule